// File: doc/BRIEF.md
# Way-Reserving Victim Selector for a Two-Thread Shared Cache

This block picks the way to replace when a miss fills one set of an N-way set-associative cache that two hardware threads share. For every set it keeps, per way, a valid flag, the ID of the thread that filled the line, and an age counter that ranks the ways from most to least recently used. Tag compare, the data array and coherence live elsewhere. The surrounding cache reports each access as a hit (with the way that hit) or a miss. On a miss it receives the chosen way one cycle later.

A configurable reservation degree Y limits any one thread to at most N - Y ways of a set. This keeps Y ways per set available to the other thread. A thread that already holds N - Y lines must recycle its own least recently used line. A thread below the limit fills an empty way first, and otherwise takes the least recently used way of the set. With Y = 0 the selector behaves as a plain LRU cache. With Y = N/2 the two threads hold fixed, separate halves of each set. A solo-mode input lifts the limit when only one thread runs. When a second thread starts, it claims ways one miss at a time, and nothing is flushed.

Top module: `way_guard_repl`

## Requirements
- R1: After reset every way of every set is empty, and `vic_valid` is low until the first miss.
- R2: A miss accepted on a clock edge gives `vic_valid` high with `vic_way` on the next cycle. A hit or an idle cycle gives `vic_valid` low on the next cycle.
- R3: A missing thread below its limit, in a set with an empty way, is given the lowest-numbered empty way.
- R4: A missing thread below its limit, in a full set, is given the least recently used way of the set. A fill or a hit makes a way the most recently used.
- R5: With solo mode off, the limit is N minus the effective degree. A missing thread that already holds that many lines of the set is given its own least recently used line, even when empty ways remain.
- R6: With solo mode on there is no limit: one thread can fill all N ways, and then LRU over the whole set applies.
- R7: A degree of 0 gives the same victims as solo mode for the same access sequence.
- R8: A degree of N/2 confines each thread to N/2 ways of a set, so each thread reuses its own half.
- R9: A degree above N/2 acts as N/2.
- R10: A hit updates recency only. It does not change which thread owns the way that hit.
- R11: Each set keeps its own state: accesses to one set do not change the victims chosen in another.
- R12: When a second thread starts in a set that the first thread filled completely, it takes the set's LRU lines one per miss. The first thread keeps its other lines until its own count reaches its limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| solo_mode | input | 1 | 1: single-thread mode, per-thread limit disabled |
| reserve_deg | input | 3 | Reservation degree Y (values above N/2 act as N/2) |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_hit | input | 1 | 1: hit on `acc_way`; 0: miss needing a victim |
| acc_set | input | 7 | Set index |
| acc_tid | input | 1 | Requesting thread (0 or 1) |
| acc_way | input | 3 | Way that hit (used only when `acc_hit` is 1) |
| vic_valid | output | 1 | Victim result valid, one cycle after a miss |
| vic_way | output | 3 | Chosen victim way |

## Verification
Directed sequences fill single sets with one thread until it reaches its limit. These separate the fill-empty-first rule from the recycle-own-line rule, because the two give different ways while empty ways remain. The same sequence runs under solo mode and under degree 0 to show that they match, and under degrees of N/2 and above to show the fixed split and the clamp. A hit by the other thread on a line it does not own, followed by a miss from the owner, tells apart a correct recency update from an ownership transfer. Long interleaved random traffic, with random degree and mode changes, is compared against an independent timestamp model.

// File: rtl/way_guard_repl.sv
module way_guard_repl #(
  parameter int WAYS = 8,
  parameter int SETS = 128,
  localparam int WW = $clog2(WAYS),
  localparam int SW = $clog2(SETS),
  localparam int DW = $clog2(WAYS / 2 + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          solo_mode,
  input  logic [DW-1:0] reserve_deg,
  input  logic          acc_valid,
  input  logic          acc_hit,
  input  logic [SW-1:0] acc_set,
  input  logic          acc_tid,
  input  logic [WW-1:0] acc_way,
  output logic          vic_valid,
  output logic [WW-1:0] vic_way
);

  logic [WAYS-1:0] valid_q [SETS];
  logic [WAYS-1:0] owner_q [SETS];
  logic [WW-1:0]   age_q   [SETS][WAYS];

  logic [WAYS-1:0] cur_valid, cur_own, mine, cand;
  logic [WW:0]     own_cnt, cap, eff_deg;
  logic            at_cap, any_free, miss;
  logic [WW-1:0]   free_way, lru_way, nxt_way, touch_way, touch_age, best_age;

  assign miss      = acc_valid && !acc_hit;
  assign cur_valid = valid_q[acc_set];
  assign cur_own   = owner_q[acc_set];
  assign mine      = cur_valid & (acc_tid ? cur_own : ~cur_own);
  assign eff_deg   = (int'(reserve_deg) > WAYS / 2) ? (WW+1)'(WAYS / 2) : (WW+1)'(reserve_deg);
  assign cap       = solo_mode ? (WW+1)'(WAYS) : (WW+1)'(WAYS) - eff_deg;
  assign at_cap    = !solo_mode && (own_cnt >= cap);
  assign any_free  = ~&cur_valid;
  assign cand      = at_cap ? mine : '1;
  assign nxt_way   = (!at_cap && any_free) ? free_way : lru_way;
  assign touch_way = miss ? nxt_way : acc_way;
  assign touch_age = age_q[acc_set][touch_way];

  always_comb begin
    own_cnt = '0;
    for (int i = 0; i < WAYS; i++) own_cnt = own_cnt + (WW+1)'(mine[i]);
  end

  always_comb begin
    free_way = '0;
    for (int i = WAYS - 1; i >= 0; i--)
      if (!cur_valid[i]) free_way = WW'(i);
  end

  always_comb begin
    lru_way  = '0;
    best_age = '0;
    for (int i = 0; i < WAYS; i++)
      if (cand[i] && age_q[acc_set][i] >= best_age) begin
        best_age = age_q[acc_set][i];
        lru_way  = WW'(i);
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        owner_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= WW'(w);
      end
      vic_valid <= 1'b0;
      vic_way   <= '0;
    end else begin
      vic_valid <= miss;
      vic_way   <= nxt_way;
      if (acc_valid) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WW'(w) == touch_way)
            age_q[acc_set][w] <= '0;
          else if (age_q[acc_set][w] < touch_age)
            age_q[acc_set][w] <= age_q[acc_set][w] + 1'b1;
        end
        if (miss) begin
          valid_q[acc_set][nxt_way] <= 1'b1;
          owner_q[acc_set][nxt_way] <= acc_tid;
        end
      end
    end
  end

endmodule

// File: rtl/way_guard_repl_chk.sv
module way_guard_repl_chk #(
  parameter int WAYS = 8,
  localparam int WW = $clog2(WAYS),
  localparam int DW = $clog2(WAYS / 2 + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            solo_mode,
  input logic [DW-1:0]   reserve_deg,
  input logic            acc_valid,
  input logic            acc_hit,
  input logic [WAYS-1:0] cur_valid,
  input logic [WAYS-1:0] mine,
  input logic [WW-1:0]   nxt_way,
  input logic            vic_valid
);

  int lim;
  assign lim = WAYS - ((int'(reserve_deg) > WAYS / 2) ? WAYS / 2 : int'(reserve_deg));

  p_vic_after_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_hit) |=> vic_valid);

  p_quiet_on_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && !acc_hit) |=> !vic_valid);

  p_free_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_hit && !solo_mode && $countones(mine) < lim && !(&cur_valid))
      |-> !cur_valid[nxt_way]);

  p_own_at_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_hit && !solo_mode && $countones(mine) >= lim)
      |-> mine[nxt_way]);

  p_solo_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_hit && solo_mode && !(&cur_valid)) |-> !cur_valid[nxt_way]);

endmodule

bind way_guard_repl way_guard_repl_chk #(.WAYS(WAYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .solo_mode(solo_mode), .reserve_deg(reserve_deg),
  .acc_valid(acc_valid), .acc_hit(acc_hit), .cur_valid(cur_valid),
  .mine(mine), .nxt_way(nxt_way), .vic_valid(vic_valid)
);

// File: tb/tb_way_guard_repl.sv
module tb_way_guard_repl;
  localparam int N = 8;
  localparam int S = 128;

  logic clk = 0;
  logic rst_n = 0;
  logic solo_mode = 0;
  logic [2:0] reserve_deg = 0;
  logic acc_valid = 0, acc_hit = 0, acc_tid = 0;
  logic [6:0] acc_set = 0;
  logic [2:0] acc_way = 0;
  logic vic_valid;
  logic [2:0] vic_way;

  always #2.5 clk = ~clk;

  way_guard_repl dut (
    .clk(clk), .rst_n(rst_n), .solo_mode(solo_mode), .reserve_deg(reserve_deg),
    .acc_valid(acc_valid), .acc_hit(acc_hit), .acc_set(acc_set), .acc_tid(acc_tid),
    .acc_way(acc_way), .vic_valid(vic_valid), .vic_way(vic_way)
  );

  int total = 0, bad = 0;
  bit done = 0;
  int exp_q[$];
  string tag_q[$];

  bit m_val [S][N];
  bit m_own [S][N];
  int m_stamp [S][N];
  int now_t = 0;

  function automatic int model_victim(int s, bit t);
    int lim, cnt, v, best;
    lim = solo_mode ? N : N - ((reserve_deg > 4) ? 4 : int'(reserve_deg));
    cnt = 0;
    for (int w = 0; w < N; w++) if (m_val[s][w] && m_own[s][w] == t) cnt++;
    v = -1; best = 0;
    if (!solo_mode && cnt >= lim) begin
      for (int w = 0; w < N; w++)
        if (m_val[s][w] && m_own[s][w] == t && (v < 0 || m_stamp[s][w] < best)) begin
          v = w; best = m_stamp[s][w];
        end
      return v;
    end
    for (int w = 0; w < N; w++) if (!m_val[s][w]) return w;
    for (int w = 0; w < N; w++)
      if (v < 0 || m_stamp[s][w] < best) begin v = w; best = m_stamp[s][w]; end
    return v;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_miss(int s, bit t, int hand, string tag);
    int v;
    @(negedge clk);
    v = model_victim(s, t);
    exp_q.push_back(hand >= 0 ? hand : v);
    tag_q.push_back(tag);
    m_val[s][v] = 1; m_own[s][v] = t; now_t++; m_stamp[s][v] = now_t;
    acc_valid = 1; acc_hit = 0; acc_set = 7'(s); acc_tid = t; acc_way = 0;
    @(posedge clk); #1 acc_valid = 0;
  endtask

  task automatic do_hit(int s, bit t, int w, bit chk);
    @(negedge clk);
    now_t++; m_stamp[s][w] = now_t;
    acc_valid = 1; acc_hit = 1; acc_set = 7'(s); acc_tid = t; acc_way = 3'(w);
    @(posedge clk); #1 acc_valid = 0;
    if (chk) begin
      @(negedge clk);
      check(vic_valid == 0, "R2 no victim after hit", int'(vic_valid), 0);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && vic_valid) begin
      if (exp_q.size() == 0) check(0, "R2 unexpected victim", int'(vic_way), -1);
      else begin
        int e; string tg;
        e = exp_q.pop_front(); tg = tag_q.pop_front();
        check(int'(vic_way) == e, tg, int'(vic_way), e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      check(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(vic_valid == 0, "R1 reset vic_valid", int'(vic_valid), 0);
    rst_n = 1;
    @(negedge clk);
    check(vic_valid == 0, "R1 idle after reset", int'(vic_valid), 0);

    // R3/R5: degree 2, thread 0 limited to 6 ways
    reserve_deg = 2;
    for (int i = 0; i < 6; i++) do_miss(3, 0, i, "R3 free way first");
    do_miss(3, 0, 0, "R5 own LRU at limit");
    do_miss(3, 0, 1, "R5 own LRU at limit");
    do_miss(3, 1, 6, "R3 reserved way for other thread");
    do_miss(3, 1, 7, "R3 reserved way for other thread");
    do_miss(3, 1, 2, "R4 LRU of full set");
    do_miss(3, 1, 3, "R4 LRU of full set");

    // R6: solo mode
    solo_mode = 1;
    for (int i = 0; i < 8; i++) do_miss(10, 0, i, "R6 solo fills all ways");
    do_miss(10, 0, 0, "R6 solo LRU");
    do_hit(10, 0, 1, 1);
    do_miss(10, 0, 2, "R4 hit refreshes recency");

    // R7: degree 0 matches solo
    solo_mode = 0; reserve_deg = 0;
    for (int i = 0; i < 8; i++) do_miss(11, 0, i, "R7 degree 0 fills all ways");
    do_miss(11, 0, 0, "R7 degree 0 LRU");
    do_hit(11, 0, 1, 1);
    do_miss(11, 0, 2, "R7 degree 0 after hit");

    // R10: hit by other thread keeps owner
    reserve_deg = 2;
    for (int i = 0; i < 6; i++) do_miss(12, 0, i, "R3 fill");
    do_hit(12, 1, 0, 1);
    do_miss(12, 0, 1, "R10 hit updates recency not owner");

    // R8: static split
    reserve_deg = 4;
    for (int i = 0; i < 4; i++) do_miss(20, 0, i, "R8 half fill");
    do_miss(20, 0, 0, "R8 reuse own half");
    do_miss(20, 0, 1, "R8 reuse own half");
    for (int i = 4; i < 8; i++) do_miss(20, 1, i, "R8 other half");
    do_miss(20, 1, 4, "R8 other reuses own half");

    // R9: clamp
    reserve_deg = 7;
    for (int i = 0; i < 4; i++) do_miss(21, 0, i, "R9 clamp fill");
    do_miss(21, 0, 0, "R9 degree above half acts as half");

    // R11: independent sets
    reserve_deg = 2;
    do_miss(30, 0, 0, "R11 set independence");
    do_miss(31, 0, 0, "R11 set independence");
    do_miss(30, 0, 1, "R11 set independence");
    do_miss(31, 1, 1, "R11 set independence");

    // R12: lazy claim after solo fill
    solo_mode = 1;
    for (int i = 0; i < 8; i++) do_miss(40, 0, i, "R12 solo prefill");
    solo_mode = 0; reserve_deg = 2;
    do_miss(40, 1, 0, "R12 lazy claim");
    do_miss(40, 1, 1, "R12 lazy claim");
    do_miss(40, 0, 2, "R12 first thread at limit");
    do_miss(40, 1, 3, "R12 claim continues by LRU");

    // random traffic against model
    for (int k = 0; k < 3000; k++) begin
      int s, w; bit t;
      s = 50 + int'($urandom_range(0, 3));
      t = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 99) < 3) reserve_deg = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 99) < 2) solo_mode = ~solo_mode;
      w = int'($urandom_range(0, N - 1));
      if ($urandom_range(0, 2) == 0 && m_val[s][w]) do_hit(s, t, w, 0);
      else do_miss(s, t, -1, "R4 random traffic model");
    end

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R2 all misses answered", exp_q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule